// File: doc/BRIEF.md
# Three-Level Phase-Reversal Carrier Pulse Generator

The block turns a stream of data bits into two digital pulse trains. When an external analog stage adds them and low-pass filters the sum, they form a binary phase-shift-keyed carrier. Timing comes from an internal tick strobe. The strobe is divided down from the system clock, and its rate is twelve ticks per carrier period. One output drives the positive lobe of a three-level waveform and the other drives the negative lobe. Each lobe is one third of the carrier period wide. A zero bit is sent at 0° phase. A one bit is sent at 180° phase, which the block produces by exchanging the roles of the two outputs. The phase can change only at the boundary between bits, and every bit lasts a fixed number of carrier periods.

Data enters over a valid/ready handshake into a single holding slot. A transfer is either a whole byte, sent most significant bit first, or a single bit. While one transfer is on the line, the next can wait in the slot, so back-to-back transfers run without a gap. One clock-wide request pulse warns of every bit boundary one tick in advance, so a caller feeding single bits can supply the next bit in time. If the slot is empty at the last boundary, the block stops there, both outputs rest low and the busy flag drops.

Top module: `pwm_bpsk_tx`

## Requirements
- R1: After reset, posOut, negOut, busy and bitReq are low and dataReady is high.
- R2: While a 0 bit is sent, each carrier period has 12 ticks numbered 0 to 11. posOut is high on ticks 1 to 4 and negOut is high on ticks 7 to 10. Each output appears one clock after the tick state that sets it.
- R3: While a 1 bit is sent, the outputs are exchanged: negOut is high on ticks 1 to 4 and posOut is high on ticks 7 to 10.
- R4: posOut and negOut are never high in the same clock.
- R5: A tick lasts CLK_PER_TICK clocks. Every bit spans CYCLES_PER_BIT carrier periods (24 by default), so a byte keeps busy high for 8 × 24 × 12 × CLK_PER_TICK clocks.
- R6: In byte mode (bitMode = 0) the 8 bits of dataIn are sent most significant first.
- R7: In bit mode (bitMode = 1) a transfer carries one bit, taken from dataIn[0].
- R8: dataReady is high exactly when the one-entry holding slot is empty. A transfer is taken on a clock edge where dataValid and dataReady are both high.
- R9: bitReq is a one-clock pulse, issued while busy, in the first clock of the last tick of every bit.
- R10: At a bit boundary with no bits left in the current transfer, a waiting transfer starts at once with no gap. If the slot is empty, busy falls at that boundary. Both outputs stay low while busy is low.
- R11: When the block is idle and the slot becomes full, busy rises on the next clock edge, and that edge is tick 0 of the first carrier period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dataValid | input | 1 | Transfer offered |
| dataIn | input | DATA_W | Byte to send, or the bit in dataIn[0] in bit mode |
| bitMode | input | 1 | 1: transfer is a single bit; 0: a whole byte |
| dataReady | output | 1 | Holding slot empty |
| busy | output | 1 | A transfer is on the line |
| bitReq | output | 1 | One-clock warning, one tick before a bit boundary |
| posOut | output | 1 | Positive-lobe pulse output |
| negOut | output | 1 | Negative-lobe pulse output |

## Verification
The bench builds the block with CLK_PER_TICK = 2 and leaves the other parameters at their defaults. A bit therefore lasts 576 clocks, which leaves room in the run for several full bytes, back-to-back transfers, a stream of single bits and a restart after an idle gap. A divider of two still separates ticks from clocks, so off-by-one errors in the divider, in the tick position of bitReq and in the one-clock output register show up at the ports. The model is fed only from the handshake, and from it the bench predicts every output clock by clock, including the exact clock in which busy falls and the edge at which a waiting transfer starts.

// File: rtl/pwm_bpsk_pkg.sv
package pwm_bpsk_pkg;

  // Strobes handed from the sequencer to the data path every clock.
  typedef struct packed {
    logic active;    // a transfer is on the line
    logic loadHold;  // capture dataIn into the holding slot
    logic takeHold;  // move the holding slot into the shift register
    logic shiftBit;  // advance to the next bit of the current transfer
    logic posWin;    // current tick lies in the early lobe window
    logic negWin;    // current tick lies in the late lobe window
  } txStrobes_t;

endpackage

// File: rtl/pwm_bpsk_ctrl.sv
module pwm_bpsk_ctrl
  import pwm_bpsk_pkg::*;
#(
  parameter int CLK_PER_TICK    = 32,
  parameter int TICKS_PER_CYCLE = 12,
  parameter int CYCLES_PER_BIT  = 24,
  parameter int DATA_W          = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataValid,
  input  logic       bitMode,
  output logic       dataReady,
  output logic       busy,
  output logic       bitReq,
  output txStrobes_t strobes
);

  localparam int DIV_W   = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam int PH_W    = $clog2(TICKS_PER_CYCLE);
  localparam int CY_W    = (CYCLES_PER_BIT > 1) ? $clog2(CYCLES_PER_BIT) : 1;
  localparam int BL_W    = $clog2(DATA_W + 1);
  localparam int PULSE_W = TICKS_PER_CYCLE / 3;
  localparam int POS_LO  = 1;
  localparam int POS_HI  = POS_LO + PULSE_W - 1;
  localparam int NEG_LO  = POS_LO + TICKS_PER_CYCLE / 2;
  localparam int NEG_HI  = NEG_LO + PULSE_W - 1;

  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_TICK - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(TICKS_PER_CYCLE - 1);
  localparam logic [PH_W-1:0]  PH_PRE   = PH_W'(TICKS_PER_CYCLE - 2);
  localparam logic [CY_W-1:0]  CY_LAST  = CY_W'(CYCLES_PER_BIT - 1);
  localparam logic [BL_W-1:0]  BL_ONE   = BL_W'(1);
  localparam logic [BL_W-1:0]  BL_FULL  = BL_W'(DATA_W);

  logic [DIV_W-1:0] divCnt;
  logic [PH_W-1:0]  phase;
  logic [CY_W-1:0]  carrier;
  logic [BL_W-1:0]  bitsLeft;
  logic             active;
  logic             holdFull;
  logic             holdSingle;

  logic tick, lastCarrier, boundary, preBoundary, acceptNow;
  logic startIdle, takeHold, shiftBit, goIdle;

  always_comb begin
    tick        = active && (divCnt == DIV_LAST);
    lastCarrier = (carrier == CY_LAST);
    boundary    = tick && (phase == PH_LAST) && lastCarrier;
    preBoundary = tick && (phase == PH_PRE) && lastCarrier;
    acceptNow   = dataValid && !holdFull;
    startIdle   = !active && holdFull;
    takeHold    = startIdle || (boundary && (bitsLeft == BL_ONE) && holdFull);
    shiftBit    = boundary && (bitsLeft != BL_ONE);
    goIdle      = boundary && (bitsLeft == BL_ONE) && !holdFull;
  end

  // Tick divider: parked at zero while idle so a start is tick-aligned.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                divCnt <= '0;
    else if (!active || tick) divCnt <= '0;
    else                      divCnt <= divCnt + DIV_W'(1);
  end

  // Position inside the carrier period and inside the bit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      carrier <= '0;
    end else if (!active) begin
      phase   <= '0;
      carrier <= '0;
    end else if (tick) begin
      if (phase == PH_LAST) begin
        phase   <= '0;
        carrier <= lastCarrier ? '0 : carrier + CY_W'(1);
      end else begin
        phase <= phase + PH_W'(1);
      end
    end
  end

  // Transfer sequencing.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      bitsLeft <= '0;
    end else begin
      if (startIdle)   active <= 1'b1;
      else if (goIdle) active <= 1'b0;

      if (takeHold)      bitsLeft <= holdSingle ? BL_ONE : BL_FULL;
      else if (shiftBit) bitsLeft <= bitsLeft - BL_ONE;
    end
  end

  // Holding-slot occupancy; accept and take can never coincide.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull   <= 1'b0;
      holdSingle <= 1'b0;
    end else if (takeHold) begin
      holdFull <= 1'b0;
    end else if (acceptNow) begin
      holdFull   <= 1'b1;
      holdSingle <= bitMode;
    end
  end

  // One-clock warning on entry to the last tick of a bit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitReq <= 1'b0;
    else       bitReq <= preBoundary;
  end

  always_comb begin
    strobes.active   = active;
    strobes.loadHold = acceptNow;
    strobes.takeHold = takeHold;
    strobes.shiftBit = shiftBit;
    strobes.posWin   = (phase >= PH_W'(POS_LO)) && (phase <= PH_W'(POS_HI));
    strobes.negWin   = (phase >= PH_W'(NEG_LO)) && (phase <= PH_W'(NEG_HI));
  end

  assign dataReady = !holdFull;
  assign busy      = active;

endmodule

// File: rtl/pwm_bpsk_dp.sv
module pwm_bpsk_dp
  import pwm_bpsk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobes_t        strobes,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              bitMode,
  output logic              posOut,
  output logic              negOut
);

  logic [DATA_W-1:0] holdData;
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] slotValue;
  logic              curBit;
  logic              posNext, negNext;

  // A single bit is parked in the top position so it leaves first.
  generate
    if (DATA_W > 1) begin : g_wide
      assign slotValue = bitMode ? {dataIn[0], (DATA_W-1)'(0)} : dataIn;
    end else begin : g_narrow
      assign slotValue = dataIn;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 holdData <= '0;
    else if (strobes.loadHold) holdData <= slotValue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 shiftReg <= '0;
    else if (strobes.takeHold) shiftReg <= holdData;
    else if (strobes.shiftBit) shiftReg <= shiftReg << 1;
  end

  // Phase reversal: a 1 bit swaps which output owns which lobe.
  always_comb begin
    curBit  = shiftReg[DATA_W-1];
    posNext = strobes.active && (curBit ? strobes.negWin : strobes.posWin);
    negNext = strobes.active && (curBit ? strobes.posWin : strobes.negWin);
  end

  // Registered so the analog summer sees clean, glitch-free edges.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posOut <= 1'b0;
      negOut <= 1'b0;
    end else begin
      posOut <= posNext;
      negOut <= negNext;
    end
  end

endmodule

// File: rtl/pwm_bpsk_tx.sv
module pwm_bpsk_tx
  import pwm_bpsk_pkg::*;
#(
  parameter int CLK_PER_TICK    = 32,
  parameter int TICKS_PER_CYCLE = 12,
  parameter int CYCLES_PER_BIT  = 24,
  parameter int DATA_W          = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              bitMode,
  output logic              dataReady,
  output logic              busy,
  output logic              bitReq,
  output logic              posOut,
  output logic              negOut
);

  txStrobes_t strobes;

  pwm_bpsk_ctrl #(
    .CLK_PER_TICK   (CLK_PER_TICK),
    .TICKS_PER_CYCLE(TICKS_PER_CYCLE),
    .CYCLES_PER_BIT (CYCLES_PER_BIT),
    .DATA_W         (DATA_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dataValid(dataValid),
    .bitMode  (bitMode),
    .dataReady(dataReady),
    .busy     (busy),
    .bitReq   (bitReq),
    .strobes  (strobes)
  );

  pwm_bpsk_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .dataIn (dataIn),
    .bitMode(bitMode),
    .posOut (posOut),
    .negOut (negOut)
  );

endmodule

// File: rtl/pwm_bpsk_tx_chk.sv
module pwm_bpsk_tx_chk (
  input logic clk,
  input logic rstN,
  input logic dataValid,
  input logic dataReady,
  input logic busy,
  input logic bitReq,
  input logic posOut,
  input logic negOut
);

  // R4: lobes are mutually exclusive
  p_lobes_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(posOut && negOut));

  // R10: outputs rest low while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!posOut && !negOut));

  // R2: a positive lobe only starts during a transfer
  p_pos_rise_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(posOut) |-> busy);

  // R9: request only while busy
  p_req_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    bitReq |-> busy);

  // R9: request is a single clock wide
  p_req_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    bitReq |=> !bitReq);

  // R8: an accepted transfer fills the slot
  p_accept_fills_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && dataReady) |=> !dataReady);

  // R11: a full slot while idle starts transmission on the next edge
  p_idle_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!dataReady && !busy) |=> busy);

endmodule

bind pwm_bpsk_tx pwm_bpsk_tx_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .dataValid(dataValid),
  .dataReady(dataReady),
  .busy     (busy),
  .bitReq   (bitReq),
  .posOut   (posOut),
  .negOut   (negOut)
);

// File: tb/pwm_bpsk_tx_tb.sv
module pwm_bpsk_tx_tb;

  localparam int DIV       = 2;
  localparam int TPC       = 12;
  localparam int CPB       = 24;
  localparam int W         = 8;
  localparam int BIT_CLKS  = DIV * TPC * CPB;
  localparam int WATCHDOG  = 200000;

  logic         clk = 1'b0;
  logic         rstN;
  logic         dataValid;
  logic [W-1:0] dataIn;
  logic         bitMode;
  logic         dataReady, busy, bitReq, posOut, negOut;

  always #10 clk = ~clk;

  pwm_bpsk_tx #(
    .CLK_PER_TICK(DIV),
    .TICKS_PER_CYCLE(TPC),
    .CYCLES_PER_BIT(CPB),
    .DATA_W(W)
  ) u_dut (
    .clk(clk), .rstN(rstN), .dataValid(dataValid), .dataIn(dataIn),
    .bitMode(bitMode), .dataReady(dataReady), .busy(busy),
    .bitReq(bitReq), .posOut(posOut), .negOut(negOut)
  );

  typedef struct { logic [W-1:0] d; logic single; } item_t;
  item_t stimQ[$];

  int errors = 0;
  int checks = 0;
  int cycle  = 0;

  // Behavioural reference state
  bit mActive = 0;
  bit mHold   = 0;
  bit mHoldSingle = 0;
  bit mHoldBits[$];
  bit mBits[$];
  bit mSingleNow = 0;
  int mClk = 0;
  bit expPos = 0, expNeg = 0, expReq = 0;

  // Busy-length measurement for R5
  int riseAt = -1;
  bit lenChecked = 0;
  bit prevBusy = 0;

  always @(posedge clk) cycle <= cycle + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cycle, act, exp);
    end
  endtask

  function automatic bit lobeA(input int c);
    int ph;
    ph = (c / DIV) % TPC;
    return (ph >= 1 && ph <= 4);
  endfunction

  function automatic bit lobeB(input int c);
    int ph;
    ph = (c / DIV) % TPC;
    return (ph >= 7 && ph <= 10);
  endfunction

  task automatic loadFromHold();
    mBits = mHoldBits;
    mSingleNow = mHoldSingle;
    mHold = 0;
    mClk = 0;
  endtask

  task automatic modelEdge();
    bit accept;
    bit cur;
    accept = dataValid && !mHold;
    cur = (mBits.size() > 0) ? mBits[0] : 1'b0;
    expPos = mActive && (cur ? lobeB(mClk) : lobeA(mClk));
    expNeg = mActive && (cur ? lobeA(mClk) : lobeB(mClk));
    if (!mActive) begin
      if (mHold) begin
        mActive = 1;
        loadFromHold();
      end
    end else if (mClk == BIT_CLKS - 1) begin
      void'(mBits.pop_front());
      if (mBits.size() > 0)  mClk = 0;
      else if (mHold)        loadFromHold();
      else                   mActive = 0;
    end else begin
      mClk++;
    end
    if (accept) begin
      mHold = 1;
      mHoldSingle = stimQ[0].single;
      mHoldBits.delete();
      if (stimQ[0].single) mHoldBits.push_back(stimQ[0].d[0]);
      else for (int i = W - 1; i >= 0; i--) mHoldBits.push_back(stimQ[0].d[i]);
      void'(stimQ.pop_front());
    end
    expReq = mActive && (mClk == BIT_CLKS - DIV);
  endtask

  task automatic compareNow();
    string tag;
    bit cur;
    cur = (mBits.size() > 0) ? mBits[0] : 1'b0;
    if (mSingleNow) tag = "R7";
    else            tag = cur ? "R3/R6" : "R2/R6";
    chk(posOut == expPos, {tag, " posOut"}, posOut, expPos);
    chk(negOut == expNeg, {tag, " negOut"}, negOut, expNeg);
    chk(!(posOut && negOut), "R4 both lobes high", 1, 0);
    chk(busy == mActive, "R10/R11 busy", busy, mActive);
    chk(dataReady == !mHold, "R8 dataReady", dataReady, !mHold);
    chk(bitReq == expReq, "R9 bitReq", bitReq, expReq);
    if (busy && !prevBusy) riseAt = cycle;
    if (!busy && prevBusy && !lenChecked && riseAt >= 0) begin
      lenChecked = 1;
      chk((cycle - riseAt) == W * BIT_CLKS, "R5 byte duration",
          cycle - riseAt, W * BIT_CLKS);
    end
    prevBusy = busy;
  endtask

  task automatic drive();
    dataValid = (stimQ.size() > 0);
    if (stimQ.size() > 0) begin
      dataIn  = stimQ[0].d;
      bitMode = stimQ[0].single;
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    modelEdge();
    @(negedge clk);
    compareNow();
    drive();
  endtask

  task automatic runIdle();
    do step(); while (!(stimQ.size() == 0 && !mActive && !mHold));
    repeat (5) step();
  endtask

  task automatic pushByte(input logic [W-1:0] b);
    item_t it;
    it.d = b; it.single = 1'b0;
    stimQ.push_back(it);
  endtask

  task automatic pushBit(input logic v);
    item_t it;
    it.d = {{(W-1){1'b1}}, v}; it.single = 1'b1;
    stimQ.push_back(it);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected<%0d cycles", WATCHDOG, WATCHDOG);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; dataValid = 1'b0; dataIn = '0; bitMode = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(posOut == 1'b0, "R1 posOut", posOut, 0);
    chk(negOut == 1'b0, "R1 negOut", negOut, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(bitReq == 1'b0, "R1 bitReq", bitReq, 0);
    chk(dataReady == 1'b1, "R1 dataReady", dataReady, 1);
    rstN = 1'b1;

    // R5/R6: lone byte, also measured for duration
    pushByte(8'hA5);
    drive();
    runIdle();

    // R10: back-to-back bytes with valid held
    pushByte(8'h00); pushByte(8'hFF); pushByte(8'h3C);
    drive();
    runIdle();

    // R7: stream of single bits; dataIn upper bits set to show they are ignored
    pushBit(1'b1); pushBit(1'b0); pushBit(1'b1); pushBit(1'b1);
    drive();
    runIdle();

    // Mixed byte then bit
    pushByte(8'h81); pushBit(1'b0);
    drive();
    runIdle();

    // R11: restart after an idle gap
    pushBit(1'b1);
    drive();
    runIdle();
    repeat (10) step();
    pushBit(1'b0);
    drive();
    runIdle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule